// File: doc/BRIEF.md
# UART Interrupt Status and Masking Unit

This block collects the interrupt causes of a UART. Single-cycle event pulses from the receive path, the transmit path, the receive timeout logic, the line-error detectors and the modem-status lines set sticky bits in an 11-bit raw status register. Software uses a small word-addressed register bus to program an enable mask, read the raw and masked status, and clear raw bits with a write-one-to-clear access. A write to the transmit data offset also raises the transmit cause.

The masked vector, raw AND enable, drives six registered, active-high interrupt lines. One line combines every masked cause. Three lines carry the receive, transmit and timeout causes on their own. One line collects the four modem causes and one collects the four line-error causes. An interrupt controller can take the combined line, or it can route the grouped lines to separate handlers.

Top module: `uart_irq_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, the raw status, the enable mask and all six interrupt outputs read zero.
- R2: Bit positions of the status vector: 0 RI, 1 CTS, 2 DCD, 3 DSR, 4 receive, 5 transmit, 6 receive timeout, 7 framing, 8 parity, 9 break, 10 overrun. A high bit on `evt_set` in one cycle sets that raw bit at the next clock edge, and the bit stays set until it is cleared.
- R3: A write to offset 0 (transmit data) sets raw bit 5.
- R4: A write to offset 4 (clear) clears each raw bit whose written data bit is 1. Raw bits written as 0 keep their value.
- R5: When a set from an event or a transmit write hits the same bit as a clear in one cycle, the bit ends up set.
- R6: A read of offset 1 returns the raw status, offset 2 the mask, offset 3 raw AND mask. Offsets 5 to 7 return zero. A write to offset 2 loads the mask. Read data appears with `rd_valid` on the cycle after the request and shows the state before that edge.
- R7: `irq_any` is the OR of all 11 masked bits.
- R8: `irq_rx`, `irq_tx` and `irq_rto` each equal the masked bit 4, 5 and 6 on its own.
- R9: `irq_modem` is the OR of masked bits 0 to 3, and `irq_err` is the OR of masked bits 7 to 10.
- R10: The outputs change on the same clock edge as the raw status or mask change that causes them, whether the change comes from a mask write, a clear or an event.
- R11: Writes to offsets 1, 3, 5, 6 and 7 change neither the raw status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 11 | Per-cause set pulses, one bit per status position |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | Word offset |
| req_wdata | input | 11 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 11 | Read data |
| irq_any | output | 1 | OR of all masked causes |
| irq_rx | output | 1 | Masked receive cause |
| irq_tx | output | 1 | Masked transmit cause |
| irq_rto | output | 1 | Masked receive timeout cause |
| irq_modem | output | 1 | OR of masked modem causes |
| irq_err | output | 1 | OR of masked line-error causes |

## Verification
The assertions assume that `evt_set` and the bus inputs are known values whenever reset is low, and that a bus write and event pulses may coincide in the same cycle. They make no assumption about how often events arrive. The stimulus changes inputs only on the falling clock edge. It drives events alone, writes alone, and on purpose an event together with a clear that covers the same bit, so the set-over-clear priority is exercised inside those limits. Every cause bit is also driven on its own with the mask fully open, so each output group sees each of its members.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int NUM_SRC   = 11;
    localparam int ADDR_W    = 3;
    localparam int NUM_LINES = 6;

    // cause bit positions
    localparam int B_RI    = 0;
    localparam int B_CTS   = 1;
    localparam int B_DCD   = 2;
    localparam int B_DSR   = 3;
    localparam int B_RX    = 4;
    localparam int B_TX    = 5;
    localparam int B_RTO   = 6;
    localparam int B_FRAME = 7;
    localparam int B_PAR   = 8;
    localparam int B_BRK   = 9;
    localparam int B_OVR   = 10;

    typedef logic [NUM_SRC-1:0] irq_vec_t;

    typedef enum logic [ADDR_W-1:0] {
        OFS_TXDATA = 3'd0,
        OFS_RAW    = 3'd1,
        OFS_MASK   = 3'd2,
        OFS_MASKED = 3'd3,
        OFS_CLEAR  = 3'd4
    } reg_ofs_e;

    // output line index
    typedef enum int {
        LN_ANY   = 0,
        LN_RX    = 1,
        LN_TX    = 2,
        LN_RTO   = 3,
        LN_MODEM = 4,
        LN_ERR   = 5
    } line_e;

    typedef struct packed {
        logic tx_we;
        logic mask_we;
        logic clr_we;
        irq_vec_t wdata;
    } wr_ctl_t;

    function automatic irq_vec_t bit_of(input int idx);
        irq_vec_t v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

    function automatic irq_vec_t line_mask(input int line);
        case (line)
            LN_ANY:   return '1;
            LN_RX:    return bit_of(B_RX);
            LN_TX:    return bit_of(B_TX);
            LN_RTO:   return bit_of(B_RTO);
            LN_MODEM: return bit_of(B_RI) | bit_of(B_CTS) | bit_of(B_DCD) | bit_of(B_DSR);
            default:  return bit_of(B_FRAME) | bit_of(B_PAR) | bit_of(B_BRK) | bit_of(B_OVR);
        endcase
    endfunction

endpackage

// File: rtl/uart_irq_regif.sv
module uart_irq_regif
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  irq_vec_t          req_wdata,
    input  irq_vec_t          raw_q,
    input  irq_vec_t          mask_q,
    output wr_ctl_t           wr,
    output logic              rd_valid,
    output irq_vec_t          rd_data
);

    logic     wr_req;
    logic     rd_req;
    irq_vec_t rd_mux;

    assign wr_req = req_valid && req_write;
    assign rd_req = req_valid && !req_write;

    always_comb begin
        wr.tx_we   = wr_req && (req_addr == OFS_TXDATA);
        wr.mask_we = wr_req && (req_addr == OFS_MASK);
        wr.clr_we  = wr_req && (req_addr == OFS_CLEAR);
        wr.wdata   = req_wdata;
    end

    always_comb begin
        case (req_addr)
            OFS_RAW:    rd_mux = raw_q;
            OFS_MASK:   rd_mux = mask_q;
            OFS_MASKED: rd_mux = raw_q & mask_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            rd_data  <= rd_req ? rd_mux : '0;
        end
    end

    // at most one write strobe per cycle
    assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
        $countones({wr.tx_we, wr.mask_we, wr.clr_we}) <= 1);

    assert_rd_follows_req_R6: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> rd_valid);

endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_vec_t evt_set,
    input  wr_ctl_t  wr,
    output irq_vec_t raw_q,
    output irq_vec_t mask_q,
    output irq_vec_t raw_d,
    output irq_vec_t mask_d
);

    irq_vec_t set_vec;
    irq_vec_t clr_vec;

    assign set_vec = evt_set | (wr.tx_we ? bit_of(B_TX) : '0);
    assign clr_vec = wr.clr_we ? wr.wdata : '0;

    // set has priority over clear
    assign raw_d  = (raw_q & ~clr_vec) | set_vec;
    assign mask_d = wr.mask_we ? wr.wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= '0;
            mask_q <= '0;
        end else begin
            raw_q  <= raw_d;
            mask_q <= mask_d;
        end
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((raw_q & $past(evt_set)) == $past(evt_set)));

    assert_tx_write_sets_R3: assert property (@(posedge clk) disable iff (rst)
        wr.tx_we |=> raw_q[B_TX]);

    assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
        (wr.clr_we && !wr.tx_we) |=>
            ((raw_q & $past(wr.wdata) & ~$past(evt_set)) == '0));

    assert_no_spurious_rise_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(set_vec)) == '0));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        wr.mask_we |=> (mask_q == $past(wr.wdata)));

    assert_mask_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !wr.mask_we |=> $stable(mask_q));

endmodule

// File: rtl/uart_irq_combine.sv
module uart_irq_combine
    import uart_irq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  irq_vec_t             raw_d,
    input  irq_vec_t             mask_d,
    output logic [NUM_LINES-1:0] irq_q
);

    irq_vec_t masked_d;
    assign masked_d = raw_d & mask_d;

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        localparam irq_vec_t SEL = line_mask(k);
        always_ff @(posedge clk) begin
            if (rst) irq_q[k] <= 1'b0;
            else     irq_q[k] <= |(masked_d & SEL);
        end
    end

    // combined line is high whenever any grouped line is high
    assert_any_covers_groups_R7: assert property (@(posedge clk) disable iff (rst)
        (|irq_q[NUM_LINES-1:1]) |-> irq_q[LN_ANY]);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_SRC-1:0] evt_set,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NUM_SRC-1:0] req_wdata,
    output logic              rd_valid,
    output logic [NUM_SRC-1:0] rd_data,
    output logic              irq_any,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              irq_rto,
    output logic              irq_modem,
    output logic              irq_err
);

    wr_ctl_t              wr;
    irq_vec_t             raw_q, mask_q, raw_d, mask_d;
    logic [NUM_LINES-1:0] irq_q;

    uart_irq_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .raw_q     (raw_q),
        .mask_q    (mask_q),
        .wr        (wr),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    uart_irq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_set (evt_set),
        .wr      (wr),
        .raw_q   (raw_q),
        .mask_q  (mask_q),
        .raw_d   (raw_d),
        .mask_d  (mask_d)
    );

    uart_irq_combine u_combine (
        .clk    (clk),
        .rst    (rst),
        .raw_d  (raw_d),
        .mask_d (mask_d),
        .irq_q  (irq_q)
    );

    assign irq_any   = irq_q[LN_ANY];
    assign irq_rx    = irq_q[LN_RX];
    assign irq_tx    = irq_q[LN_TX];
    assign irq_rto   = irq_q[LN_RTO];
    assign irq_modem = irq_q[LN_MODEM];
    assign irq_err   = irq_q[LN_ERR];

    // outputs track the registered state on the same edge (R10)
    assert_any_level_R7: assert property (@(posedge clk) disable iff (rst)
        irq_any == |(raw_q & mask_q));

    assert_single_lines_R8: assert property (@(posedge clk) disable iff (rst)
        {irq_rx, irq_tx, irq_rto} ==
        {raw_q[B_RX] & mask_q[B_RX], raw_q[B_TX] & mask_q[B_TX], raw_q[B_RTO] & mask_q[B_RTO]});

    assert_modem_group_R9: assert property (@(posedge clk) disable iff (rst)
        irq_modem == |(raw_q[B_DSR:B_RI] & mask_q[B_DSR:B_RI]));

    assert_err_group_R9: assert property (@(posedge clk) disable iff (rst)
        irq_err == |(raw_q[B_OVR:B_FRAME] & mask_q[B_OVR:B_FRAME]));

    assert_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (raw_q == $past(raw_q) && mask_q == $past(mask_q)) |-> $stable(irq_q));

endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] evt_set = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [2:0]    req_addr = '0;
    logic [NS-1:0] req_wdata = '0;
    logic          rd_valid;
    logic [NS-1:0] rd_data;
    logic          irq_any, irq_rx, irq_tx, irq_rto, irq_modem, irq_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NS-1:0] m_raw  = '0;
    logic [NS-1:0] m_mask = '0;

    logic [NS-1:0] exp_q[$];
    string         tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl u_uart_irq_ctrl (
        .clk(clk), .rst(rst), .evt_set(evt_set),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .irq_any(irq_any), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rto(irq_rto),
        .irq_modem(irq_modem), .irq_err(irq_err)
    );

    task automatic check(input string tag, input logic [NS-1:0] act, input logic [NS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_lines(input string tag);
        logic [NS-1:0] mk;
        logic [5:0] exp6;
        mk = m_raw & m_mask;
        exp6 = {|mk[10:7], |mk[3:0], mk[6], mk[5], mk[4], |mk};
        check(tag, {5'b0, irq_err, irq_modem, irq_rto, irq_tx, irq_rx, irq_any}, {5'b0, exp6});
    endtask

    // monitor: pops expected read data
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6 actual=unexpected_read expected=none");
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [NS-1:0] d, input logic [NS-1:0] ev);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; evt_set = ev;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; evt_set = '0;
        if (a == 3'd2) m_mask = d;
        m_raw = (m_raw & ~((a == 3'd4) ? d : '0)) | ev | ((a == 3'd0) ? 11'h020 : '0);
    endtask

    task automatic pulse(input logic [NS-1:0] ev);
        @(negedge clk);
        evt_set = ev;
        @(negedge clk);
        evt_set = '0;
        m_raw = m_raw | ev;
    endtask

    task automatic bus_read(input logic [2:0] a, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        case (a)
            3'd1: exp_q.push_back(m_raw);
            3'd2: exp_q.push_back(m_mask);
            3'd3: exp_q.push_back(m_raw & m_mask);
            default: exp_q.push_back('0);
        endcase
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_lines("R1 outputs in reset");
        rst = 1'b0;
        @(negedge clk);
        check_lines("R1 outputs after reset");
        bus_read(3'd1, "R1 raw after reset");
        bus_read(3'd2, "R1 mask after reset");

        pulse(11'h010);
        check_lines("R7 masked off rx");
        bus_read(3'd1, "R2 raw rx set");
        bus_read(3'd3, "R6 masked zero");

        bus_write(3'd2, 11'h010, '0);
        check_lines("R10 mask write raises rx");
        bus_read(3'd2, "R6 mask readback");

        bus_write(3'd0, 11'h041, '0);
        check_lines("R3 tx write masked");
        bus_read(3'd1, "R3 raw tx set");

        bus_write(3'd2, 11'h7FF, '0);
        check_lines("R8 tx line open");
        pulse(11'h004);
        check_lines("R9 modem line dcd");
        pulse(11'h200);
        check_lines("R9 err line break");
        bus_read(3'd3, "R6 masked all");

        bus_write(3'd4, 11'h010, '0);
        check_lines("R4 clear rx only");
        bus_read(3'd1, "R4 others kept");

        bus_write(3'd4, 11'h040, 11'h040);
        check_lines("R5 set wins lines");
        bus_read(3'd1, "R5 set wins raw");

        bus_write(3'd1, 11'h7FF, '0);
        bus_write(3'd3, 11'h000, '0);
        bus_write(3'd6, 11'h000, '0);
        check_lines("R11 ignored writes lines");
        bus_read(3'd1, "R11 raw unchanged");
        bus_read(3'd2, "R11 mask unchanged");
        bus_read(3'd5, "R6 unused offset zero");

        bus_write(3'd4, 11'h7FF, '0);
        check_lines("R4 clear all");
        for (int i = 0; i < NS; i++) begin
            pulse(11'(1) << i);
            check_lines($sformatf("R2 R9 single bit %0d", i));
            bus_write(3'd4, 11'(1) << i, '0);
            check_lines($sformatf("R4 clear bit %0d", i));
        end

        bus_write(3'd2, 11'h600, '0);
        pulse(11'h7FF);
        check_lines("R9 partial mask err");
        bus_write(3'd2, 11'h000, '0);
        check_lines("R10 mask close");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R6 actual=%0d pending expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule